// File: doc/BRIEF.md
# Rail Fault and Thermal Supervisor

This block watches the supply rails of a power controller. Each rail has an undervoltage flag, and the sequencer marks whether that rail's monitor is armed. The block also reads a digital die-temperature code. From these it drives one registered fault output and one enable per rail. For each rail, a parameter says whether its pass element is on chip (internal) or off chip (external).

An undervoltage on an external-pass rail only raises the fault. An undervoltage on an internal-pass rail also latches that rail off. The sequencer can mark the start-up window, the span after the standby rails are up and before the other rails come up. An undervoltage on a standby rail inside this window locks out the whole device, and only a bias reset (`rst_n`) releases it.

Temperature has two thresholds. At the warning level the block raises the fault and keeps running. At the trip level it turns every rail off, and the rails come back only when the temperature falls below the warning level. Holding the active-low shutdown request low turns all rails off, drops the fault, and releases any rail that was latched off.

Top module: `rail_supervisor`

## Requirements
- R1: An undervoltage flag on an armed rail (bit i of `uv_flag` and bit i of `mon_armed` both 1) sets `fault` to 1 at the clock edge after it is sampled, provided `shdn_n` is high.
- R2: An undervoltage flag on a rail whose `mon_armed` bit is 0 has no effect: `fault`, `rail_en` and `lockout` stay as they would be without it.
- R3: An undervoltage on an external-pass rail (bit i of `INT_PASS` is 0; rails 1 and 3 by default) raises `fault` but leaves `rail_en[i]` at 1.
- R4: An undervoltage on an internal-pass rail (bit i of `INT_PASS` is 1; rails 0 and 2 by default) clears `rail_en[i]` only. The rail stays off, and `fault` stays 1, after the flag goes away.
- R5: While `shdn_n` is 0, `fault` is 0 and every `rail_en` bit is 0 from the next edge on. Every rail latched off under R4 is released, so all rails read 1 again once `shdn_n` returns high.
- R6: With `startup_win` high, an armed undervoltage on a standby rail (bit i of `STBY_MASK` is 1; rails 0 and 1 by default) sets `lockout`. While `lockout` is set, `fault` is 1 and all `rail_en` bits are 0. A shutdown pulse does not clear `lockout`; only `rst_n` does.
- R7: A `temp_code` at or above `T_WARN` (140) sets `fault` while the rails stay enabled.
- R8: A `temp_code` at or above `T_TRIP` (155) turns every rail off. The rails stay off while the temperature stays at or above `T_WARN`, and come back once it drops below `T_WARN`.
- R9: `fault` returns to 0 on the edge after every cause is gone: no armed undervoltage, no latched rail, no lockout, and a temperature below `T_WARN`.
- R10: While `rst_n` is low, `fault`, `lockout` and every `rail_en` bit are 0. On the first edge after release with `shdn_n` high, all rails are enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; models bias power cycling |
| shdn_n | input | 1 | Active-low external shutdown request |
| startup_win | input | 1 | High during the start-up window, from the sequencer |
| mon_armed | input | N_RAILS | Per-rail monitor armed, from the sequencer |
| uv_flag | input | N_RAILS | Per-rail undervoltage flag (rail below 80% of set value) |
| temp_code | input | TEMP_W | Die temperature code in °C |
| fault | output | 1 | Registered fault output |
| rail_en | output | N_RAILS | Per-rail enable, 1 = rail allowed on |
| lockout | output | 1 | Whole-device latch-off after a start-up standby-rail fault |

## Verification
The assertions assume that inputs change only between clock edges and that `temp_code` is a plain unsigned reading. They also assume the sequencer holds `startup_win` steady for whole cycles. The bench drives every input on the falling edge and samples on the next falling edge. Each pattern is applied for whole cycles, and every latched state is cleared by a shutdown pulse or a reset before the next pattern starts. Both temperature sweeps move one code per cycle, so the hysteresis band is crossed in both directions.

// File: rtl/rsv_pkg.sv
// Shared types for the rail supervisor.
// Assumes: temperature codes are unsigned integers in degrees.
package rsv_pkg;

    // Thermal condition reported by the thermal guard
    typedef enum logic [1:0] {
        TH_COOL = 2'd0,
        TH_WARM = 2'd1,
        TH_TRIP = 2'd2
    } therm_e;

    // Rail pass-element kind
    typedef enum logic {
        PASS_EXT = 1'b0,
        PASS_INT = 1'b1
    } pass_e;

endpackage

// File: rtl/rsv_rail_latch.sv
// One rail's latch-off state.
// An internal-pass rail latches off on a qualified undervoltage.
// An external-pass rail never latches.
// Assumes: uv_hit is already qualified by the monitor-arm bit.
module rsv_rail_latch
    import rsv_pkg::*;
#(
    parameter pass_e KIND = PASS_EXT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shdn_n,
    input  logic uv_hit,
    output logic off_nx,
    output logic off_q
);

    // Next latch state: shutdown clears, internal undervoltage sets
    always_comb begin
        if (!shdn_n)
            off_nx = 1'b0;
        else
            off_nx = off_q | ((KIND == PASS_INT) & uv_hit);
    end

    // Latch-off register
    always_ff @(posedge clk) begin
        if (!rst_n) off_q <= 1'b0;
        else        off_q <= off_nx;
    end

    // R5: a shutdown request releases the latch
    a_r5_latch_release: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |=> !off_q);

    generate
        if (KIND == PASS_INT) begin : g_int
            // R4: an internal rail latches off on a qualified undervoltage
            a_r4_int_latch: assert property (@(posedge clk) disable iff (!rst_n)
                (shdn_n && uv_hit) |=> off_q);
            // R4: the latch holds until a shutdown arrives
            a_r4_int_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (off_q && shdn_n) |=> off_q);
        end
    endgenerate

endmodule

// File: rtl/rsv_startup_lock.sv
// Whole-device lockout.
// Set by a standby-rail undervoltage inside the start-up window.
// Cleared only by reset.
// Assumes: stby_hit is qualified by the monitor-arm bits.
module rsv_startup_lock (
    input  logic clk,
    input  logic rst_n,
    input  logic startup_win,
    input  logic stby_hit,
    output logic lock_nx,
    output logic lock_q
);

    // Next lock state: sticky once set
    always_comb lock_nx = lock_q | (startup_win & stby_hit);

    // Lock register, cleared only by bias reset
    always_ff @(posedge clk) begin
        if (!rst_n) lock_q <= 1'b0;
        else        lock_q <= lock_nx;
    end

    // R6: a start-up standby fault engages the lock
    a_r6_lock_set: assert property (@(posedge clk) disable iff (!rst_n)
        (startup_win && stby_hit) |=> lock_q);

    // R6: the lock never releases without reset
    a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);

endmodule

// File: rtl/rsv_thermal.sv
// Two-threshold thermal guard with hysteresis.
// warm: the temperature is at or above the warning level.
// trip: set at the trip level, cleared once the temperature falls below the warning level.
// Assumes: T_WARN < T_TRIP < 2**TEMP_W.
module rsv_thermal
    import rsv_pkg::*;
#(
    parameter int TEMP_W = 8,
    parameter int T_WARN = 140,
    parameter int T_TRIP = 155
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TEMP_W-1:0] temp_code,
    output logic              warm,
    output logic              trip_nx,
    output therm_e            state
);

    localparam logic [TEMP_W-1:0] WARN_C = TEMP_W'(T_WARN);
    localparam logic [TEMP_W-1:0] TRIP_C = TEMP_W'(T_TRIP);

    logic trip_q;
    logic hot_now;

    // Threshold compares
    always_comb begin
        warm    = (temp_code >= WARN_C);
        hot_now = (temp_code >= TRIP_C);
    end

    // Hysteresis: set at trip, hold in band, clear below warning
    always_comb begin
        if (hot_now)    trip_nx = 1'b1;
        else if (!warm) trip_nx = 1'b0;
        else            trip_nx = trip_q;
    end

    // Trip register
    always_ff @(posedge clk) begin
        if (!rst_n) trip_q <= 1'b0;
        else        trip_q <= trip_nx;
    end

    // Condition summary for neighbours
    always_comb begin
        if (trip_q)    state = TH_TRIP;
        else if (warm) state = TH_WARM;
        else           state = TH_COOL;
    end

    // R8: reaching the trip level trips the guard
    a_r8_trip_set: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_code >= TRIP_C) |=> trip_q);

    // R8: falling below the warning level releases the guard
    a_r8_trip_resume: assert property (@(posedge clk) disable iff (!rst_n)
        (temp_code < WARN_C) |=> !trip_q);

    // R8: the guard holds inside the hysteresis band
    a_r8_trip_band: assert property (@(posedge clk) disable iff (!rst_n)
        (trip_q && temp_code >= WARN_C) |=> trip_q);

endmodule

// File: rtl/rail_supervisor.sv
// Rail fault and thermal supervisor (top).
// Qualifies the undervoltage flags with the monitor-arm bits.
// Applies the per-rail latch-off, the start-up lockout and the thermal guard.
// Registers the fault output and the per-rail enables.
// Assumes: all inputs are synchronous to clk.
// Bit i of INT_PASS and of STBY_MASK describes rail i.
module rail_supervisor
    import rsv_pkg::*;
#(
    parameter int                  N_RAILS   = 4,
    parameter int                  TEMP_W    = 8,
    parameter int                  T_WARN    = 140,
    parameter int                  T_TRIP    = 155,
    parameter logic [N_RAILS-1:0]  INT_PASS  = 4'b0101,
    parameter logic [N_RAILS-1:0]  STBY_MASK = 4'b0011
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shdn_n,
    input  logic               startup_win,
    input  logic [N_RAILS-1:0] mon_armed,
    input  logic [N_RAILS-1:0] uv_flag,
    input  logic [TEMP_W-1:0]  temp_code,
    output logic               fault,
    output logic [N_RAILS-1:0] rail_en,
    output logic               lockout
);

    localparam logic [TEMP_W-1:0] WARN_C = TEMP_W'(T_WARN);

    logic [N_RAILS-1:0] uv_hit;
    logic [N_RAILS-1:0] roff_nx;
    logic [N_RAILS-1:0] roff_q;
    logic               lock_nx;
    logic               warm;
    logic               trip_nx;
    therm_e             th_state;
    logic               fault_d;
    logic [N_RAILS-1:0] en_d;

    // Ignore flags from rails whose monitor is not yet armed
    always_comb uv_hit = uv_flag & mon_armed;

    // One latch per rail; the pass kind picks the variant
    generate
        for (genvar i = 0; i < N_RAILS; i++) begin : g_rail
            if (INT_PASS[i]) begin : g_int
                rsv_rail_latch #(.KIND(PASS_INT)) u_latch (
                    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n),
                    .uv_hit(uv_hit[i]), .off_nx(roff_nx[i]), .off_q(roff_q[i]));
            end else begin : g_ext
                rsv_rail_latch #(.KIND(PASS_EXT)) u_latch (
                    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n),
                    .uv_hit(uv_hit[i]), .off_nx(roff_nx[i]), .off_q(roff_q[i]));
            end
        end
    endgenerate

    rsv_startup_lock u_lock (
        .clk(clk), .rst_n(rst_n), .startup_win(startup_win),
        .stby_hit(|(uv_hit & STBY_MASK)),
        .lock_nx(lock_nx), .lock_q(lockout));

    rsv_thermal #(.TEMP_W(TEMP_W), .T_WARN(T_WARN), .T_TRIP(T_TRIP)) u_therm (
        .clk(clk), .rst_n(rst_n), .temp_code(temp_code),
        .warm(warm), .trip_nx(trip_nx), .state(th_state));

    // Fault and enable next values, computed from the next states
    always_comb begin
        fault_d = shdn_n & (lock_nx | (|uv_hit) | (|roff_nx) | warm);
        for (int i = 0; i < N_RAILS; i++)
            en_d[i] = shdn_n & ~lock_nx & ~trip_nx & ~roff_nx[i];
    end

    // Output registers, so the fault and enables do not glitch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault   <= 1'b0;
            rail_en <= '0;
        end else begin
            fault   <= fault_d;
            rail_en <= en_d;
        end
    end

    // R1: an armed undervoltage raises the fault
    a_r1_uv_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_n && (|(uv_flag & mon_armed))) |=> fault);

    // R5: shutdown forces the fault low and every rail off
    a_r5_shdn: assert property (@(posedge clk) disable iff (!rst_n)
        !shdn_n |=> (!fault && rail_en == '0));

    // R6: a locked device has no rail on and shows the fault
    a_r6_lock_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        (lockout && $past(shdn_n)) |-> (rail_en == '0 && fault));

    // R7: the warning level raises the fault
    a_r7_warm_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_n && temp_code >= WARN_C) |=> fault);

    // R8: the thermal trip turns every rail off
    a_r8_trip_off: assert property (@(posedge clk) disable iff (!rst_n)
        (th_state == TH_TRIP) |-> (rail_en == '0));

endmodule

// File: tb/sim_rail_supervisor.sv
module sim_rail_supervisor;

    localparam int N = 4;
    localparam logic [N-1:0] INTM = 4'b0101;
    localparam logic [N-1:0] STBM = 4'b0011;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         shdn_n = 1'b1;
    logic         startup_win = 1'b0;
    logic [N-1:0] mon_armed = '0;
    logic [N-1:0] uv_flag = '0;
    logic [7:0]   temp_code = 8'd25;
    logic         fault;
    logic [N-1:0] rail_en;
    logic         lockout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rail_supervisor u0 (
        .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n), .startup_win(startup_win),
        .mon_armed(mon_armed), .uv_flag(uv_flag), .temp_code(temp_code),
        .fault(fault), .rail_en(rail_en), .lockout(lockout));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Apply the current inputs across one rising edge; sample on the falling edge
    task automatic step();
        @(negedge clk);
    endtask

    task automatic shdn_pulse();
        shdn_n = 1'b0; step();
        shdn_n = 1'b1; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        step();
        // R10: state while held in reset
        chk("R10 fault", fault, 0);
        chk("R10 rail_en", rail_en, 0);
        chk("R10 lockout", lockout, 0);
        rst_n = 1'b1; step();
        chk("R10 rail_en after release", rail_en, 4'hF);

        // R1 R2 R3 R4 R5 R9: sweep every flag pattern against every arm pattern
        for (int a = 0; a < 16; a++) begin
            for (int u = 0; u < 16; u++) begin
                logic [N-1:0] hit;
                shdn_pulse();
                chk("R5 rails restored", rail_en, 4'hF);
                chk("R9 fault idle", fault, 0);
                mon_armed = N'(a); uv_flag = N'(u);
                hit = N'(a) & N'(u);
                step();
                chk("R1 R2 fault", fault, int'(|hit));
                chk("R3 R4 rail_en", rail_en, int'(~(hit & INTM) & 4'hF));
                uv_flag = '0; step();
                chk("R4 R9 fault after clear", fault, int'(|(hit & INTM)));
                chk("R4 latch held", rail_en, int'(~(hit & INTM) & 4'hF));
                chk("R2 no lockout", lockout, 0);
                shdn_n = 1'b0; step();
                chk("R5 fault low", fault, 0);
                chk("R5 rails off", rail_en, 0);
                shdn_n = 1'b1;
            end
        end
        mon_armed = '0;
        step();

        // R7 R8 R9: temperature sweeps in both directions
        begin
            bit hot = 1'b0;
            for (int t = 0; t < 256; t++) begin
                temp_code = 8'(t);
                if (t >= 155) hot = 1'b1; else if (t < 140) hot = 1'b0;
                step();
                chk("R7 R9 fault up", fault, int'(t >= 140));
                chk("R8 rails up", rail_en, hot ? 0 : 4'hF);
            end
            for (int t = 255; t >= 0; t--) begin
                temp_code = 8'(t);
                if (t >= 155) hot = 1'b1; else if (t < 140) hot = 1'b0;
                step();
                chk("R7 R9 fault down", fault, int'(t >= 140));
                chk("R8 rails down", rail_en, hot ? 0 : 4'hF);
            end
        end
        temp_code = 8'd25;

        // R6: start-up window fault on each rail
        for (int r = 0; r < N; r++) begin
            rst_n = 1'b0; step();
            rst_n = 1'b1; step();
            startup_win = 1'b1;
            mon_armed = N'(1 << r); uv_flag = N'(1 << r);
            step();
            uv_flag = '0; startup_win = 1'b0; step();
            chk("R6 lockout", lockout, int'(STBM[r]));
            chk("R6 fault", fault, int'(STBM[r] | INTM[r]));
            chk("R6 rails", rail_en, STBM[r] ? 0 : int'(~(N'(1 << r) & INTM) & 4'hF));
            shdn_pulse();
            chk("R6 lock survives shutdown", lockout, int'(STBM[r]));
            chk("R6 rails after shutdown", rail_en, STBM[r] ? 0 : 4'hF);
            // R2: an unarmed standby flag in the window does not lock
            rst_n = 1'b0; step();
            rst_n = 1'b1; step();
            startup_win = 1'b1; mon_armed = '0; uv_flag = N'(1 << r);
            step();
            chk("R2 unarmed window", lockout, 0);
            chk("R2 unarmed fault", fault, 0);
            startup_win = 1'b0; uv_flag = '0;
        end
        rst_n = 1'b0; step();
        chk("R6 reset clears lock", lockout, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule